// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a target FPGA over its serial configuration pins from a byte stream. A start strobe makes it pull the active-low program line, wait for the target to signal that it is clearing its configuration memory, release the program line, and wait for the target to report that it is ready. The block then takes bytes one at a time through a valid/ready handshake and shifts each one out, most significant bit first, on a data pin. A generated configuration clock carries each bit. The incoming stream flags its final byte with a last marker.

Before each byte the block checks the target's status pins for a configuration CRC fault. After the final byte it holds the data pin high and keeps the configuration clock running until the target raises its done pin. Each of the three waits is bounded by a 10 ms timeout, measured in system clock cycles. The result is either a success flag or a nonzero error code. It is held until the next start. The target's status inputs pass through two-flop synchronizers before any use.

Top module: `cfgser_master`

## Requirements
- R1: A start while idle drives `prog_n` low on the next cycle, and `busy` goes high. `prog_n` stays low until the synchronized `cfg_init_n` has been seen low, which takes two synchronizer cycles plus one state cycle. A start while `busy` is high has no effect on the load in progress.
- R2: After `prog_n` is released, no rising edge appears on `cclk` and no byte is accepted until the synchronized `cfg_init_n` is high.
- R3: Each byte is sent as 8 bits, most significant bit first. For each bit, `din` takes its value while `cclk` is low. `cclk` then rises and `din` is held through the high phase. Each phase lasts `CCLK_HALF` system cycles, so consecutive rising edges inside a byte are 2*`CCLK_HALF` cycles apart.
- R4: A byte is accepted only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only after the program line is released. A byte accepted with `in_last` high is the final byte of the load.
- R5: Before each byte is accepted, if the synchronized `cfg_init_n` is low while the synchronized `cfg_done` is low, the load ends with error code 3 (CRC fault) and no further byte is taken.
- R6: After the final byte, `din` is held at 1 while `cclk` keeps toggling until the synchronized `cfg_done` is high. The load then ends with `success` = 1 and error code 0.
- R7: Each wait ends with an error once CLK_HZ/100 cycles have passed without the expected condition. The code is 1 if `cfg_init_n` never goes low, 2 if `cfg_init_n` never returns high, and 4 if `cfg_done` never rises. For code 1, `busy` lasts exactly CLK_HZ/100 cycles.
- R8: `success` and `err_code` keep their values while idle until the next start, which clears them both. `success` is never high together with a nonzero code.
- R9: After reset, `prog_n` = 1, `busy` = 0, `success` = 0, `err_code` = 0 and `in_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (honoured only when idle) |
| in_data | input | 8 | Configuration byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | This byte is the final one |
| in_ready | output | 1 | Block takes the byte this cycle if valid |
| busy | output | 1 | A load is in progress |
| success | output | 1 | Last load completed with done seen |
| err_code | output | 3 | 0 none, 1 init-low timeout, 2 init-high timeout, 3 CRC fault, 4 done timeout |
| prog_n | output | 1 | Active-low program pulse to the target |
| cfg_init_n | input | 1 | Target's active-low init/status pin |
| cfg_done | input | 1 | Target's done pin |
| cclk | output | 1 | Configuration clock |
| din | output | 1 | Configuration serial data |

## Verification
The assertions check every cycle the properties that hold at all times. `din` never moves while `cclk` is high. `cclk` stays still while the program line is low and while the block waits for init release. `din` is 1 throughout post-load clocking. Handshake readiness never overlaps the program pulse. The status outputs never change while idle and never show success together with an error. The bench scenarios are needed for the rest. They show that the bytes reassembled by a behavioural target equal the bytes sent, that each fault pattern on the status pins maps to its error code, that the timeout length is right, and that a repeated start leaves a running load undisturbed.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_HI,
        ST_CHECK,
        ST_SHIFT,
        ST_POST
    } cfg_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_INIT_LO = 3'd1,
        ERR_INIT_HI = 3'd2,
        ERR_CRC     = 3'd3,
        ERR_DONE    = 3'd4
    } cfg_err_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              last;
    } cfg_beat_t;

    // Target flags a bitstream fault by pulling init low before done rises.
    function automatic logic crc_fault(input logic init_n_s, input logic done_s);
        return !init_n_s && !done_s;
    endfunction

endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
    parameter int             W       = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/cfgser_timer.sv
module cfgser_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfgser_shift.sv
module cfgser_shift
    import cfgser_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              halt,
    output logic              cclk,
    output logic              din,
    output logic              active,
    output logic              byte_done
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int IW = $clog2(BYTE_W);

    logic [HW-1:0]     half_cnt;
    logic [IW-1:0]     bit_idx;
    logic [BYTE_W-1:0] sr;
    logic              cclk_q, din_q;
    logic              phase_end;

    assign phase_end = (half_cnt == HW'(HALF - 1));
    assign byte_done = active && cclk_q && phase_end && (bit_idx == IW'(BYTE_W - 1));
    assign cclk      = cclk_q;
    assign din       = din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            half_cnt <= '0;
            bit_idx  <= '0;
            sr       <= '0;
            cclk_q   <= 1'b0;
            din_q    <= 1'b0;
        end else if (load) begin
            active   <= 1'b1;
            half_cnt <= '0;
            bit_idx  <= '0;
            sr       <= byte_in;
            cclk_q   <= 1'b0;
            din_q    <= byte_in[BYTE_W-1];
        end else if (halt) begin
            active   <= 1'b0;
        end else if (active) begin
            if (phase_end) begin
                half_cnt <= '0;
                if (!cclk_q) begin
                    cclk_q <= 1'b1;
                end else if (bit_idx == IW'(BYTE_W - 1)) begin
                    active <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    sr      <= sr << 1;
                    din_q   <= sr[BYTE_W-2];
                    cclk_q  <= 1'b0;
                end
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // R3
    din_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cclk_q && $past(cclk_q)) |-> $stable(din_q));

endmodule

// File: rtl/cfgser_master.sv
module cfgser_master
    import cfgser_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int CCLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  in_data,
    input  logic        in_valid,
    input  logic        in_last,
    output logic        in_ready,
    output logic        busy,
    output logic        success,
    output logic [2:0]  err_code,
    output logic        prog_n,
    input  logic        cfg_init_n,
    input  logic        cfg_done,
    output logic        cclk,
    output logic        din
);
    localparam int TMO_CYC = CLK_HZ / 100;

    cfg_state_e state_q, state_d;
    cfg_err_e   err_q, err_d;
    logic       ok_q, ok_d;
    logic       last_q, last_d;
    logic       init_s, done_s;
    logic       tmo;
    logic       sh_load, sh_active, sh_done, sh_halt;
    logic [7:0] sh_byte;
    logic       fault;
    cfg_beat_t  beat;

    assign beat = '{data: in_data, last: in_last};

    cfgser_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cfg_done, cfg_init_n}),
        .q   ({done_s, init_s})
    );

    cfgser_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state_d != state_q),
        .expired (tmo)
    );

    cfgser_shift #(.HALF(CCLK_HALF)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .byte_in   (sh_byte),
        .halt      (sh_halt),
        .cclk      (cclk),
        .din       (din),
        .active    (sh_active),
        .byte_done (sh_done)
    );

    assign fault    = crc_fault(init_s, done_s);
    assign in_ready = (state_q == ST_CHECK) && !fault;
    assign busy     = (state_q != ST_IDLE);
    assign prog_n   = (state_q != ST_PROG);
    assign success  = ok_q;
    assign err_code = err_q;

    assign sh_byte  = (state_q == ST_CHECK) ? beat.data : 8'hFF;
    assign sh_load  = ((state_q == ST_CHECK) && in_ready && in_valid) ||
                      ((state_q == ST_POST) && !sh_active && !done_s && !tmo);
    assign sh_halt  = (state_d == ST_IDLE) && (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        ok_d    = ok_q;
        last_d  = last_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PROG;
                    err_d   = ERR_NONE;
                    ok_d    = 1'b0;
                    last_d  = 1'b0;
                end
            end
            ST_PROG: begin
                if (!init_s) begin
                    state_d = ST_WAIT_HI;
                end else if (tmo) begin
                    state_d = ST_IDLE;
                    err_d   = ERR_INIT_LO;
                end
            end
            ST_WAIT_HI: begin
                if (init_s) begin
                    state_d = ST_CHECK;
                end else if (tmo) begin
                    state_d = ST_IDLE;
                    err_d   = ERR_INIT_HI;
                end
            end
            ST_CHECK: begin
                if (fault) begin
                    state_d = ST_IDLE;
                    err_d   = ERR_CRC;
                end else if (in_valid) begin
                    state_d = ST_SHIFT;
                    last_d  = beat.last;
                end
            end
            ST_SHIFT: begin
                if (sh_done)
                    state_d = last_q ? ST_POST : ST_CHECK;
            end
            ST_POST: begin
                if (done_s) begin
                    state_d = ST_IDLE;
                    ok_d    = 1'b1;
                end else if (tmo) begin
                    state_d = ST_IDLE;
                    err_d   = ERR_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
            ok_q    <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            ok_q    <= ok_d;
            last_q  <= last_d;
        end
    end

    // R1
    prog_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prog_n) |-> $past(start));

    // R2
    no_early_clk_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_PROG || state_q == ST_WAIT_HI) &&
         ($past(state_q) == ST_PROG || $past(state_q) == ST_WAIT_HI)) |-> $stable(cclk));

    // R4
    ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (prog_n && busy));

    // R6
    post_din_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST && $past(state_q) == ST_POST) |-> din);

    // R8
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        success |-> (err_code == 3'd0));

    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(start)) |-> ($stable(err_code) && $stable(success)));

endmodule

// File: tb/cfgser_master_tb.sv
module cfgser_master_tb;
    localparam int CLK_HZ = 20000;
    localparam int HALF   = 2;
    localparam int TMO    = CLK_HZ / 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       start = 0, in_valid = 0, in_last = 0;
    logic [7:0] in_data = '0;
    logic       in_ready, busy, success, prog_n, cclk, din;
    logic [2:0] err_code;
    logic       init_pin = 1, done_pin = 0;

    cfgser_master #(.CLK_HZ(CLK_HZ), .CCLK_HALF(HALF)) u_dut (
        .clk(clk), .rst(rst), .start(start), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .busy(busy), .success(success), .err_code(err_code),
        .prog_n(prog_n), .cfg_init_n(init_pin), .cfg_done(done_pin),
        .cclk(cclk), .din(din)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural target
    bit         no_lo, no_hi, no_done, data_phase, feed_stop, poke;
    int         n_exp, crc_at, k_done;
    logic [7:0] tx [8];
    logic [7:0] rx [8];
    logic [7:0] sr;
    int         rx_n, bits, extra, extra_low, early, per_bad, cyc, last_rise;
    int         busy_cyc, prog_low;

    always @(negedge clk) cyc++;

    always @(posedge cclk) begin
        if (!data_phase) begin
            early++;
        end else if (rx_n < n_exp) begin
            if ((bits % 8) != 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
            sr = {sr[6:0], din};
            bits++;
            if ((bits % 8) == 0) begin
                rx[rx_n] = sr;
                rx_n++;
                if (rx_n == crc_at) init_pin = 0;
            end
        end else begin
            extra++;
            if (!din) extra_low++;
            if (extra == k_done && !no_done) done_pin = 1;
        end
        last_rise = cyc;
    end

    task automatic target_model();
        wait (prog_n == 1'b0);
        if (!no_lo) begin
            repeat (3) @(negedge clk);
            init_pin = 0;
        end
        wait (prog_n == 1'b1);
        if (!no_lo && !no_hi) begin
            repeat (4) @(negedge clk);
            init_pin = 1;
            data_phase = 1;
        end
    endtask

    task automatic feeder();
        int  idx;
        bit  fire;
        idx = 0;
        while (idx < n_exp && !feed_stop) begin
            @(negedge clk);
            in_valid = 1;
            in_data  = tx[idx];
            in_last  = (idx == n_exp - 1);
            fire     = in_ready;
            @(posedge clk);
            if (fire) idx++;
        end
        @(negedge clk);
        in_valid = 0;
        in_last  = 0;
    endtask

    task automatic waiter();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        busy_cyc = 0;
        prog_low = 0;
        while (busy && busy_cyc < 20000) begin
            busy_cyc++;
            if (!prog_n) prog_low++;
            @(negedge clk);
            start = poke && (busy_cyc == 40);
        end
        start = 0;
        feed_stop = 1;
    endtask

    task automatic run(input int n, input int seed);
        init_pin = 1; done_pin = 0; data_phase = 0; feed_stop = 0;
        rx_n = 0; bits = 0; extra = 0; extra_low = 0; early = 0; per_bad = 0;
        n_exp = n;
        for (int i = 0; i < 8; i++) begin
            tx[i] = 8'((seed * 53 + i * 29 + 8'h3C) & 8'hFF);
            rx[i] = 8'h00;
        end
        if (seed == 99) begin
            tx[0] = 8'h80; tx[1] = 8'h01; tx[2] = 8'hFF; tx[3] = 8'h00;
        end
        repeat (4) @(negedge clk);
        fork
            target_model();
            waiter();
            feeder();
        join
        repeat (2) @(negedge clk);
    endtask

    task automatic set_mode(input bit lo, input bit hi, input int crc, input bit dn, input bit pk);
        no_lo = lo; no_hi = hi; crc_at = crc; no_done = dn; poke = pk; k_done = 5;
    endtask

    task automatic check_good(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < n_exp; i++) if (rx[i] !== tx[i]) bad++;
        check(rx_n == n_exp, {tag, " R4 byte count"}, rx_n, n_exp);
        check(bad == 0, {tag, " R3 bytes msb-first"}, bad, 0);
        check(per_bad == 0, {tag, " R3 bit period"}, per_bad, 0);
        check(early == 0, {tag, " R2 no clock before init high"}, early, 0);
        check(prog_low == 5, {tag, " R1 program pulse length"}, prog_low, 5);
        check(success == 1'b1, {tag, " R6 success"}, success, 1);
        check(err_code == 3'd0, {tag, " R8 error cleared"}, err_code, 0);
        check(extra >= k_done, {tag, " R6 post clocks"}, extra, k_done);
        check(extra_low == 0, {tag, " R6 din high after last"}, extra_low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc = 0; last_rise = 0;
        set_mode(0, 0, -1, 0, 0);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check(prog_n == 1'b1, "R9 prog_n", prog_n, 1);
        check(busy == 1'b0, "R9 busy", busy, 0);
        check(success == 1'b0, "R9 success", success, 0);
        check(err_code == 3'd0, "R9 err_code", err_code, 0);
        check(in_ready == 1'b0, "R9 in_ready", in_ready, 0);

        // Normal sweep over length and pattern
        for (int n = 1; n <= 4; n++) begin
            for (int s = 0; s < 2; s++) begin
                set_mode(0, 0, -1, 0, 0);
                run(n, s + n * 7);
                check_good("sweep");
            end
        end
        set_mode(0, 0, -1, 0, 0);
        run(4, 99);
        check_good("edge-pattern");

        // R7 init never falls
        set_mode(1, 0, -1, 0, 0);
        run(2, 3);
        check(err_code == 3'd1, "R7 init-low timeout code", err_code, 1);
        check(busy_cyc >= TMO && busy_cyc <= TMO + 1, "R7 timeout length", busy_cyc, TMO);
        check(prog_n == 1'b1, "R7 program released", prog_n, 1);
        check(rx_n == 0 && early == 0, "R2 no data on timeout", rx_n + early, 0);
        repeat (20) @(negedge clk);
        check(err_code == 3'd1 && success == 1'b0, "R8 status held", err_code, 1);

        // R7 init never returns high
        set_mode(0, 1, -1, 0, 0);
        run(2, 4);
        check(err_code == 3'd2, "R7 init-high timeout code", err_code, 2);
        check(rx_n == 0 && early == 0, "R2 no clock while init low", rx_n + early, 0);

        // R5 CRC fault after first byte
        set_mode(0, 0, 1, 0, 0);
        run(3, 5);
        check(err_code == 3'd3, "R5 crc code", err_code, 3);
        check(success == 1'b0, "R5 no success", success, 0);
        check(rx_n < 3, "R5 load stopped", rx_n, 2);

        // R7 done never rises
        set_mode(0, 0, -1, 1, 0);
        run(2, 6);
        check(err_code == 3'd4, "R7 done timeout code", err_code, 4);
        check(extra > 10, "R6 clocking continues while waiting", extra, 11);
        check(extra_low == 0, "R6 din high while waiting", extra_low, 0);

        // R1 repeated start during a load is ignored; R8 new start clears error
        set_mode(0, 0, -1, 0, 1);
        run(3, 8);
        check_good("poke R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule